// File: doc/BRIEF.md
# ADC Conversion Result Register

This block holds the most recent converter result in a 16-bit data word that software or a transfer engine reads. When the converter signals a finished conversion, the block takes the raw code, keeps only the bits that the selected resolution defines, and places them at the low or the high end of the word. The resolution and alignment in force at that moment decide the layout.

Next to the data it keeps two status flags. The first says that unread data is waiting. The second says that a result arrived while earlier data was still unread. In that case the earlier data is kept and the late result is dropped. An interrupt request follows the overrun flag when its enable is set.

A typical host loop waits for the data-ready flag and reads the word, which clears the flag. It clears the overrun flag explicitly after handling the lost sample.

Top module: `adc_result_reg`

## Requirements
- R1: After reset, `dout` is 0 and `eoc`, `ovr` and `irq` are 0.
- R2: `res_sel` encodes the result width: 0 = 12 bits, 1 = 10 bits, 2 = 8 bits, 3 = 6 bits. With `left_just` = 0 the stored word holds `conv_code[n-1:0]` in bits [n-1:0], and all higher bits are 0. Code bits at n and above are ignored.
- R3: With `left_just` = 1 and a width of 12, 10 or 8 bits, `conv_code[n-1:0]` occupies bits [15:16-n], and all lower bits are 0.
- R4: With `left_just` = 1 and 6-bit width, `conv_code[5:0]` occupies bits [7:2], and all other bits are 0.
- R5: The format is fixed at capture time. Later changes of `res_sel` or `left_just` do not alter `dout`.
- R6: A `conv_done` pulse while `eoc` is 0 loads the formatted word into `dout`, and `eoc` reads 1 from the next cycle on.
- R7: `dr_read` or `eoc_clr` without `conv_done` clears `eoc` in the next cycle and leaves `dout` unchanged.
- R8: A `conv_done` while `eoc` is 1, with neither `dr_read` nor `eoc_clr` in that cycle, sets `ovr`. In that case `dout` keeps its old value and `eoc` stays 1.
- R9: A `dr_read` or `eoc_clr` in the same cycle as `conv_done` counts as consuming the old word. The new word is loaded, `eoc` is 1 afterwards and `ovr` is not set by that completion.
- R10: `ovr` stays 1 until `ovr_clr`. If an overrun happens in the same cycle as `ovr_clr`, `ovr` stays 1.
- R11: `irq` equals `ovr` AND `ovr_ie` at all times; `ovr_ie` acts without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle pulse: a conversion finished |
| conv_code | input | 12 | Raw conversion code, significant bits at the low end |
| res_sel | input | 2 | Resolution select (0:12, 1:10, 2:8, 3:6 bits) |
| left_just | input | 1 | 1 = left-justify the result, 0 = right-justify |
| dr_read | input | 1 | One-cycle pulse: the data word is being read |
| eoc_clr | input | 1 | Clears the data-ready flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_ie | input | 1 | Overrun interrupt enable |
| dout | output | 16 | Formatted data word |
| eoc | output | 1 | Data-ready flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Overrun interrupt request |

## Verification
The interesting collision is a new completion arriving in the same cycle as a read or an explicit clear of the data-ready flag. In that case the read must win the race: the new word is loaded and no overrun is recorded. A second collision of the same kind is an overrun coinciding with an overrun clear. Directed steps place these events on the exact same edge. The random phase also produces them often, because the strobes are driven independently at high rates. Each case is judged against a per-cycle reference state, which the bench updates from the requirement text.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;

    typedef enum logic [1:0] {
        RES_12 = 2'd0,
        RES_10 = 2'd1,
        RES_8  = 2'd2,
        RES_6  = 2'd3
    } res_e;

    localparam int NUM_RES = 4;

endpackage

// File: rtl/adc_rr_format.sv
module adc_rr_format
    import adc_rr_pkg::*;
#(
    parameter int RAW_W = 12,
    parameter int DR_W  = 16
) (
    input  logic [RAW_W-1:0] code,
    input  res_e             res,
    input  logic             left,
    output logic [DR_W-1:0]  word
);
    logic [DR_W-1:0] cand [NUM_RES];

    // one formatting lane per resolution; the select picks a lane
    for (genvar r = 0; r < NUM_RES; r++) begin : g_lane
        localparam int NBITS = RAW_W - 2 * r;
        // 6-bit left justification tops out at the low byte
        localparam int LSH   = (r == NUM_RES - 1) ? (DR_W / 2 - NBITS) : (DR_W - NBITS);
        logic [DR_W-1:0] right_v;
        logic [DR_W-1:0] left_v;
        assign right_v = DR_W'(code[NBITS-1:0]);
        assign left_v  = right_v << LSH;
        assign cand[r] = left ? left_v : right_v;
    end

    always_comb begin
        word = cand[res];
    end

endmodule

// File: rtl/adc_rr_flags.sv
module adc_rr_flags (
    input  logic done,
    input  logic rd,
    input  logic eclr,
    input  logic oclr,
    input  logic eoc_q,
    input  logic ovr_q,
    output logic load,
    output logic eoc_d,
    output logic ovr_d
);
    logic consumed;
    logic overrun;

    always_comb begin
        // a read or clear in the same cycle frees the slot for the new word
        consumed = rd | eclr;
        overrun  = done & eoc_q & ~consumed;
        load     = done & ~overrun;
        eoc_d    = load ? 1'b1 : (consumed ? 1'b0 : eoc_q);
        ovr_d    = overrun | (ovr_q & ~oclr);
    end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_rr_pkg::*;
#(
    parameter int RAW_W = 12,
    parameter int DR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RAW_W-1:0] conv_code,
    input  logic [1:0]       res_sel,
    input  logic             left_just,
    input  logic             dr_read,
    input  logic             eoc_clr,
    input  logic             ovr_clr,
    input  logic             ovr_ie,
    output logic [DR_W-1:0]  dout,
    output logic             eoc,
    output logic             ovr,
    output logic             irq
);
    typedef struct packed {
        logic [DR_W-1:0] dr;
        logic            eoc;
        logic            ovr;
    } state_t;

    state_t st_q, st_d;
    logic [DR_W-1:0] fmt_word;
    logic load, eoc_nx, ovr_nx;

    adc_rr_format #(.RAW_W(RAW_W), .DR_W(DR_W)) u_fmt (
        .code (conv_code),
        .res  (res_e'(res_sel)),
        .left (left_just),
        .word (fmt_word)
    );

    adc_rr_flags u_flags (
        .done  (conv_done),
        .rd    (dr_read),
        .eclr  (eoc_clr),
        .oclr  (ovr_clr),
        .eoc_q (st_q.eoc),
        .ovr_q (st_q.ovr),
        .load  (load),
        .eoc_d (eoc_nx),
        .ovr_d (ovr_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dr  = load ? fmt_word : st_q.dr;
        st_d.eoc = eoc_nx;
        st_d.ovr = ovr_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dr;
    assign eoc  = st_q.eoc;
    assign ovr  = st_q.ovr;
    assign irq  = st_q.ovr & ovr_ie;

    // completion always leaves the data-ready flag set
    assert_eoc_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> eoc);

    // read or clear without completion drops the flag, data stays
    assert_eoc_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dr_read || eoc_clr) && !conv_done) |=> (!eoc && $stable(dout)));

    // overrun sets the flag and preserves the old word
    assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && eoc && !dr_read && !eoc_clr) |=> (ovr && $stable(dout)));

    // coincident read lets the new word in without overrun
    assert_read_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && (dr_read || eoc_clr) && !ovr) |=> !ovr);

    // overrun flag is sticky
    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    // no completion, no change of data
    assert_dout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(dout));

endmodule

// File: tb/sim_adc_result_reg.sv
`timescale 1ns/1ps
module sim_adc_result_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_done, left_just, dr_read, eoc_clr, ovr_clr, ovr_ie;
    logic [11:0] conv_code;
    logic [1:0]  res_sel;
    logic [15:0] dout;
    logic        eoc, ovr, irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m_dr;
    logic        m_eoc, m_ovr;

    always #2.5 clk = ~clk;

    adc_result_reg u0 (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_code(conv_code),
        .res_sel(res_sel), .left_just(left_just), .dr_read(dr_read),
        .eoc_clr(eoc_clr), .ovr_clr(ovr_clr), .ovr_ie(ovr_ie),
        .dout(dout), .eoc(eoc), .ovr(ovr), .irq(irq)
    );

    function automatic logic [15:0] fmt(input logic [11:0] c, input logic [1:0] r, input logic l);
        int n;
        logic [15:0] v;
        n = 12 - 2 * r;
        v = 16'(c) & ((16'd1 << n) - 16'd1);
        if (l) v = (r == 2'd3) ? (v << 2) : (v << (16 - n));
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "dout", dout, m_dr);
        chk(tag, "eoc", 16'(eoc), 16'(m_eoc));
        chk(tag, "ovr", 16'(ovr), 16'(m_ovr));
        chk(tag, "irq", 16'(irq), 16'(m_ovr & ovr_ie));
    endtask

    // drive one cycle, update the reference, compare after the edge
    task automatic step(input string tag, input logic d, input logic [11:0] c,
                        input logic [1:0] r, input logic l, input logic rd,
                        input logic ec, input logic oc, input logic ie);
        logic cons, ovev;
        conv_done = d; conv_code = c; res_sel = r; left_just = l;
        dr_read = rd; eoc_clr = ec; ovr_clr = oc; ovr_ie = ie;
        cons = rd | ec;
        ovev = d & m_eoc & ~cons;
        @(posedge clk);
        if (d && !ovev) begin m_dr = fmt(c, r, l); m_eoc = 1'b1; end
        else if (cons) m_eoc = 1'b0;
        m_ovr = ovev | (m_ovr & ~oc);
        #1;
        conv_done = 1'b0; dr_read = 1'b0; eoc_clr = 1'b0; ovr_clr = 1'b0;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        rst_n = 1'b0; conv_done = 0; conv_code = 0; res_sel = 0; left_just = 0;
        dr_read = 0; eoc_clr = 0; ovr_clr = 0; ovr_ie = 0;
        m_dr = '0; m_eoc = 0; m_ovr = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_all("R1");

        // R2 right justification, every width, upper code bits set to prove masking
        for (int r = 0; r < 4; r++) begin
            step("R2", 1, 12'hFA5, 2'(r), 0, 0, 0, 0, 0);
            step("R7", 0, 0, 0, 0, 1, 0, 0, 0);
        end
        // R3 left justification 12/10/8
        for (int r = 0; r < 3; r++) begin
            step("R3", 1, 12'h9C3, 2'(r), 1, 0, 0, 0, 0);
            step("R7", 0, 0, 0, 0, 0, 1, 0, 0);
        end
        // R4 6-bit left: FFF -> 00FC
        step("R4", 1, 12'hFFF, 2'd3, 1, 0, 0, 0, 0);
        chk("R4", "dout6", dout, 16'h00FC);
        // R5 config change after capture
        step("R5", 0, 12'h123, 2'd0, 0, 0, 0, 0, 1);
        chk("R5", "dout_kept", dout, 16'h00FC);
        // R8 overrun: eoc still set
        step("R8", 1, 12'h555, 2'd0, 0, 0, 0, 0, 1);
        chk("R11", "irq_on", 16'(irq), 16'd1);
        ovr_ie = 1'b0; #1;
        chk("R11", "irq_gated", 16'(irq), 16'd0);
        // R10 overrun together with ovr_clr keeps ovr
        step("R10", 1, 12'h0AA, 2'd1, 0, 0, 0, 1, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 1, 1);
        // R9 read races a completion
        step("R9", 1, 12'h3C3, 2'd0, 1, 1, 0, 0, 1);
        chk("R9", "ovr_clear", 16'(ovr), 16'd0);
        step("R9", 1, 12'h7E1, 2'd2, 0, 0, 1, 0, 1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            step("R6", ($urandom % 3) == 0, 12'($urandom), 2'($urandom),
                 1'($urandom), ($urandom % 4) == 0, ($urandom % 8) == 0,
                 ($urandom % 6) == 0, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule